// File: doc/BRIEF.md
# Trigger and Interrupt Routing Matrix

This block sits between a boundary-scan controller and a backplane's shared trigger and interrupt lines. On the way in, it picks one of eight active-low trigger lines for each of the controller's four event inputs. On the way out, it steers the controller's single interrupt either onto one of seven interrupt-request lines or onto one of the trigger lines.

Software programs two 16-bit routing words. The input-routing word holds one 4-bit field per event input. The top bit of each field enables the route and the lower three bits name the trigger line. The output-routing word has three parts:
- a field that steers the interrupt onto a request line;
- a field that steers the interrupt onto a trigger line;
- a 3-bit choice of trigger line to serve as an external test-clock source.

Its upper bits are spare but are kept. Both words can be read back unchanged.

Incoming trigger lines pass through a two-stage synchronizer before they reach an event output. The outgoing routes are decoded without a register, so they follow the controller interrupt directly. Outgoing trigger drives are pull-low enables for an open-drain pad. The block has no streaming data path, so every pin is a plain level or strobe with no valid/ready handshake and no back-pressure.

Top module: `trig_irq_router`

## Requirements
- R1: After reset both routing words read zero, every event output is 0, no request line is raised and no trigger line is pulled, whatever the trigger lines and the controller interrupt are doing.
- R2: Event k (k = 0..3) is decided by input-word bits [4k+3:4k]. Bit 4k+3 = 1 enables the route and bits [4k+2:4k] give the trigger line number. An enabled event is 1 while the named trigger line is low.
- R3: An event whose enable bit is 0 stays at 0, whatever the trigger lines are doing.
- R4: The input-routing read-back port returns the last value written, in the cycle after the write strobe.
- R5: A change on a trigger line reaches an enabled event output after exactly two rising clock edges, and not after one.
- R6: Output-word bits [3:0] steer the interrupt onto a request line. With bit 3 = 1 and bits [2:0] = n (1..7), request bit n-1 equals the controller interrupt. With bit 3 = 0 or bits [2:0] = 0, no request bit is raised.
- R7: Output-word bits [7:4] steer the interrupt onto a trigger line. With bit 7 = 1, pull bit [6:4] equals the controller interrupt (1 means drive that line low). With bit 7 = 0, nothing is pulled.
- R8: The test-clock source output equals output-word bits [10:8]. The output read-back returns the whole written word, including the spare bits [15:11], in the cycle after the write strobe.
- R9: At most one request bit and at most one trigger pull bit are active at any time, and none is active while the controller interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in_n | input | 8 | Backplane trigger lines as sensed, active low |
| ctl_irq | input | 1 | Controller interrupt, active high |
| in_sel_we | input | 1 | Write strobe for the input-routing word |
| in_sel_wdata | input | 16 | Input-routing word write data |
| out_sel_we | input | 1 | Write strobe for the output-routing word |
| out_sel_wdata | input | 16 | Output-routing word write data |
| event_o | output | 4 | Event inputs of the controller, active high |
| irq_req | output | 7 | One-hot request vector; bit n-1 drives request line n |
| trig_pull | output | 8 | Pull-low enables for the trigger lines |
| tck_src_sel | output | 3 | Trigger line picked as test-clock source |
| in_sel_rdata | output | 16 | Input-routing word read-back |
| out_sel_rdata | output | 16 | Output-routing word read-back |

## Verification
The bench builds the block with its default parameters: eight trigger lines, four events, seven request lines and 4-bit fields. With these values every field code from 0 to 15 is a legal stimulus, including selects of the highest trigger line and of request line 7. Random routing words, trigger patterns and interrupt levels then reach every decode case, and directed steps pin down the two-edge synchronizer delay and the request-index-zero case.

// File: rtl/trig_route_pkg.sv
package trig_route_pkg;
  localparam int TRIG_LINES = 8;
  localparam int EVENT_CNT  = 4;
  localparam int IRQ_LINES  = 7;
  localparam int WORD_W     = 16;
  localparam int IDX_W      = $clog2(TRIG_LINES);
  localparam int FIELD_W    = IDX_W + 1;

  typedef struct packed {
    logic             en;
    logic [IDX_W-1:0] idx;
  } route_field_t;
endpackage

// File: rtl/route_word_reg.sv
module route_word_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_n,
  output logic [W-1:0] active
);
  logic [W-1:0] stage1_n, stage2_n;

  // Reset to the released (high) level so nothing looks active.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_n <= '1;
      stage2_n <= '1;
    end else begin
      stage1_n <= line_n;
      stage2_n <= stage1_n;
    end
  end

  assign active = ~stage2_n;
endmodule

// File: rtl/event_select.sv
module event_select
  import trig_route_pkg::*;
#(
  parameter int NTRIG  = TRIG_LINES,
  parameter int NEVENT = EVENT_CNT,
  parameter int FW     = FIELD_W
) (
  input  logic [NEVENT*FW-1:0] sel_word,
  input  logic [NTRIG-1:0]     trig_act,
  output logic [NEVENT-1:0]    event_o
);
  for (genvar k = 0; k < NEVENT; k++) begin : g_evt
    route_field_t fld;
    assign fld        = route_field_t'(sel_word[k*FW +: FW]);
    assign event_o[k] = fld.en & trig_act[fld.idx];
  end
endmodule

// File: rtl/irq_out_decode.sv
module irq_out_decode
  import trig_route_pkg::*;
#(
  parameter int NIRQ  = IRQ_LINES,
  parameter int NTRIG = TRIG_LINES,
  parameter int FW    = FIELD_W
) (
  input  logic            ctl_irq,
  input  logic [FW-1:0]   irq_field,
  input  logic [FW-1:0]   trg_field,
  output logic [NIRQ-1:0] irq_req,
  output logic [NTRIG-1:0] trig_pull
);
  route_field_t ifld, tfld;
  assign ifld = route_field_t'(irq_field);
  assign tfld = route_field_t'(trg_field);

  // Request line n sits at bit n-1; index 0 selects nothing.
  for (genvar n = 1; n <= NIRQ; n++) begin : g_irq
    assign irq_req[n-1] = ctl_irq & ifld.en & (ifld.idx == IDX_W'(n));
  end

  for (genvar t = 0; t < NTRIG; t++) begin : g_pull
    assign trig_pull[t] = ctl_irq & tfld.en & (tfld.idx == IDX_W'(t));
  end
endmodule

// File: rtl/trig_irq_router.sv
module trig_irq_router
  import trig_route_pkg::*;
#(
  parameter int NTRIG  = TRIG_LINES,
  parameter int NEVENT = EVENT_CNT,
  parameter int NIRQ   = IRQ_LINES,
  parameter int WW     = WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NTRIG-1:0]  trig_in_n,
  input  logic              ctl_irq,
  input  logic              in_sel_we,
  input  logic [WW-1:0]     in_sel_wdata,
  input  logic              out_sel_we,
  input  logic [WW-1:0]     out_sel_wdata,
  output logic [NEVENT-1:0] event_o,
  output logic [NIRQ-1:0]   irq_req,
  output logic [NTRIG-1:0]  trig_pull,
  output logic [IDX_W-1:0]  tck_src_sel,
  output logic [WW-1:0]     in_sel_rdata,
  output logic [WW-1:0]     out_sel_rdata
);
  localparam int FW      = FIELD_W;
  localparam int TCK_LSB = 2 * FW;

  logic [WW-1:0]    in_word, out_word;
  logic [NTRIG-1:0] trig_act;

  route_word_reg #(.W(WW)) i_in_reg (
    .clk(clk), .rst_n(rst_n), .we(in_sel_we), .wdata(in_sel_wdata), .q(in_word)
  );

  route_word_reg #(.W(WW)) i_out_reg (
    .clk(clk), .rst_n(rst_n), .we(out_sel_we), .wdata(out_sel_wdata), .q(out_word)
  );

  trig_sync #(.W(NTRIG)) i_sync (
    .clk(clk), .rst_n(rst_n), .line_n(trig_in_n), .active(trig_act)
  );

  event_select #(.NTRIG(NTRIG), .NEVENT(NEVENT), .FW(FW)) i_evt (
    .sel_word(in_word[NEVENT*FW-1:0]), .trig_act(trig_act), .event_o(event_o)
  );

  irq_out_decode #(.NIRQ(NIRQ), .NTRIG(NTRIG), .FW(FW)) i_out (
    .ctl_irq(ctl_irq),
    .irq_field(out_word[FW-1:0]),
    .trg_field(out_word[2*FW-1:FW]),
    .irq_req(irq_req),
    .trig_pull(trig_pull)
  );

  assign tck_src_sel   = out_word[TCK_LSB +: IDX_W];
  assign in_sel_rdata  = in_word;
  assign out_sel_rdata = out_word;
endmodule

// File: rtl/trig_irq_router_chk.sv
module trig_irq_router_chk
  import trig_route_pkg::*;
#(
  parameter int NTRIG  = TRIG_LINES,
  parameter int NEVENT = EVENT_CNT,
  parameter int NIRQ   = IRQ_LINES,
  parameter int WW     = WORD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_irq,
  input logic              in_sel_we,
  input logic [WW-1:0]     in_sel_wdata,
  input logic              out_sel_we,
  input logic [WW-1:0]     out_sel_wdata,
  input logic [NEVENT-1:0] event_o,
  input logic [NIRQ-1:0]   irq_req,
  input logic [NTRIG-1:0]  trig_pull,
  input logic [WW-1:0]     in_sel_rdata,
  input logic [WW-1:0]     out_sel_rdata
);
  assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_req) && $onehot0(trig_pull));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_irq |-> (irq_req == '0) && (trig_pull == '0));

  assert_in_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_sel_we |=> in_sel_rdata == $past(in_sel_wdata));

  assert_out_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_sel_we |=> out_sel_rdata == $past(out_sel_wdata));

  assert_irq_routed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_irq && out_sel_rdata[3] && out_sel_rdata[2:0] != 3'd0) |-> irq_req != '0);

  for (genvar k = 0; k < NEVENT; k++) begin : g_dis
    assert_event_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !in_sel_rdata[k*FIELD_W + IDX_W] |-> !event_o[k]);
  end
endmodule

bind trig_irq_router trig_irq_router_chk #(
  .NTRIG(NTRIG), .NEVENT(NEVENT), .NIRQ(NIRQ), .WW(WW)
) i_chk (
  .clk(clk), .rst_n(rst_n), .ctl_irq(ctl_irq),
  .in_sel_we(in_sel_we), .in_sel_wdata(in_sel_wdata),
  .out_sel_we(out_sel_we), .out_sel_wdata(out_sel_wdata),
  .event_o(event_o), .irq_req(irq_req), .trig_pull(trig_pull),
  .in_sel_rdata(in_sel_rdata), .out_sel_rdata(out_sel_rdata)
);

// File: tb/test_trig_irq_router.sv
module test_trig_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  trig_in_n = 8'hFF;
  logic        ctl_irq = 1'b0;
  logic        in_sel_we = 1'b0;
  logic [15:0] in_sel_wdata = '0;
  logic        out_sel_we = 1'b0;
  logic [15:0] out_sel_wdata = '0;
  logic [3:0]  event_o;
  logic [6:0]  irq_req;
  logic [7:0]  trig_pull;
  logic [2:0]  tck_src_sel;
  logic [15:0] in_sel_rdata, out_sel_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  trig_irq_router i_trig_irq_router (
    .clk(clk), .rst_n(rst_n), .trig_in_n(trig_in_n), .ctl_irq(ctl_irq),
    .in_sel_we(in_sel_we), .in_sel_wdata(in_sel_wdata),
    .out_sel_we(out_sel_we), .out_sel_wdata(out_sel_wdata),
    .event_o(event_o), .irq_req(irq_req), .trig_pull(trig_pull),
    .tck_src_sel(tck_src_sel), .in_sel_rdata(in_sel_rdata), .out_sel_rdata(out_sel_rdata)
  );

  function automatic logic [3:0] exp_evt(logic [15:0] s, logic [7:0] tn);
    logic [3:0] r = '0;
    for (int k = 0; k < 4; k++) begin
      logic [3:0] f = s[k*4 +: 4];
      r[k] = f[3] & ~tn[f[2:0]];
    end
    return r;
  endfunction

  function automatic logic [6:0] exp_irq(logic [15:0] o, logic i);
    logic [6:0] r = '0;
    if (i && o[3] && o[2:0] != 3'd0) r[o[2:0] - 3'd1] = 1'b1;
    return r;
  endfunction

  function automatic logic [7:0] exp_pull(logic [15:0] o, logic i);
    logic [7:0] r = '0;
    if (i && o[7]) r[o[6:4]] = 1'b1;
    return r;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge; the words load at the next rising edge.
  task automatic apply(logic [15:0] s, logic [15:0] o, logic [7:0] tn, logic i);
    @(negedge clk);
    in_sel_wdata = s; in_sel_we = 1'b1;
    out_sel_wdata = o; out_sel_we = 1'b1;
    trig_in_n = tn; ctl_irq = i;
    @(negedge clk);
    in_sel_we = 1'b0; out_sel_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_all(string tag, logic [15:0] s, logic [15:0] o, logic [7:0] tn, logic i);
    chk({tag, " R2 event"}, 16'(event_o), 16'(exp_evt(s, tn)));
    chk({tag, " R6 irq"}, 16'(irq_req), 16'(exp_irq(o, i)));
    chk({tag, " R7 pull"}, 16'(trig_pull), 16'(exp_pull(o, i)));
    chk({tag, " R4 in readback"}, in_sel_rdata, s);
    chk({tag, " R8 out readback"}, out_sel_rdata, o);
    chk({tag, " R8 tck"}, 16'(tck_src_sel), 16'(o[10:8]));
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240601));
    ctl_irq = 1'b1;
    trig_in_n = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 event", 16'(event_o), 16'h0);
    chk("R1 irq", 16'(irq_req), 16'h0);
    chk("R1 pull", 16'(trig_pull), 16'h0);
    chk("R1 in word", in_sel_rdata, 16'h0);
    chk("R1 out word", out_sel_rdata, 16'h0);

    // R3: every field disabled, every line active
    apply(16'h7777, 16'h0000, 8'h00, 1'b0);
    chk("R3 disabled", 16'(event_o), 16'h0);

    // R5: two-edge latency from line 0 to event0
    apply(16'h0008, 16'h0000, 8'hFF, 1'b0);
    @(negedge clk);
    trig_in_n = 8'hFE;
    @(negedge clk);
    chk("R5 one edge", 16'(event_o), 16'h0);
    @(negedge clk);
    chk("R5 two edges", 16'(event_o), 16'h1);

    // R6: index zero with enable routes nowhere; index 7 hits top bit
    apply(16'h0000, 16'h0008, 8'hFF, 1'b1);
    chk("R6 index0", 16'(irq_req), 16'h0);
    apply(16'h0000, 16'h000F, 8'hFF, 1'b1);
    chk("R6 index7", 16'(irq_req), 16'h40);
    // R7: trigger-out onto line 7
    apply(16'h0000, 16'h00F0, 8'hFF, 1'b1);
    chk("R7 line7", 16'(trig_pull), 16'h80);
    // R8: spare bits kept, tck field
    apply(16'h0000, 16'hFD00, 8'hFF, 1'b0);
    chk("R8 spare", out_sel_rdata, 16'hFD00);
    chk("R8 tck5", 16'(tck_src_sel), 16'h5);
    // R9: interrupt low releases everything
    apply(16'h0000, 16'h00FF, 8'hFF, 1'b0);
    chk("R9 idle irq", 16'(irq_req), 16'h0);
    chk("R9 idle pull", 16'(trig_pull), 16'h0);

    for (int it = 0; it < 300; it++) begin
      logic [15:0] s = 16'($urandom);
      logic [15:0] o = 16'($urandom);
      logic [7:0]  tn = 8'($urandom);
      logic        i = 1'($urandom);
      apply(s, o, tn, i);
      check_all("rand", s, o, tn, i);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule